// File: doc/BRIEF.md
# Strap Latch and Power-Down Sequencer

This block sits beside the clock outputs of a clock generator. It shares one input pin between two jobs. At power-up the pin is an active-low power-good signal. The first time the synchronized pin is seen low, the block captures two frequency-select straps. It latches them as read-only status and decodes them into a CPU clock rate code. After that capture the straps and the pin no longer change the latched values, except in test mode. From then on the same pin is an active-high power-down request.

A power-down request is synchronized to the reference clock and must be seen high on two consecutive samples before it is accepted. Once it is accepted, each output lane is parked at its next falling transition. When every lane is parked, the block grants permission to stop the oscillators. When the pin drops again, the block issues a one-cycle restart pulse. It keeps every lane parked until an external lock indication is high. A test-select input takes over the outputs, and a test-mode input chooses between tri-stating them and driving a divided reference.

Top module: `strap_pd_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the block shows: straps_valid=0, strap_status=2'b00, rate_code=1, out_hold all zero, osc_off_ok=0 and restart_pulse=0.
- R2: rate_code is decoded from strap_status {sel_hi, sel_lo} as follows: 2'b10 gives 0 (100 MHz), 2'b00 gives 1 (133 MHz), 2'b01 gives 2 (166 MHz) and 2'b11 gives 3 (200 MHz). strap_status[1] is sel_hi and strap_status[0] is sel_lo.
- R3: pg_pd_pin passes through a two-stage synchronizer. Suppose the pin is driven low just after edge N and no capture has happened yet. Then the straps are latched at edge N+3 and straps_valid rises at that same edge.
- R4: Outside test mode, once straps_valid is set, later changes on sel_hi, sel_lo or pg_pd_pin leave strap_status unchanged.
- R5: straps_valid, once set, falls only on reset.
- R6: A power-down is accepted only when the synchronized pin is high on two consecutive clock edges, straps_valid=1 and test_sel=0. A pin pulse one cycle wide never parks any lane.
- R7: Suppose the pin is driven high just after edge N. Parking is armed from edge N+4. Lane i parks at the edge after lane_level[i] has been seen going from 1 to 0 while armed, and out_hold[i]=1 from then on.
- R8: osc_off_ok is 1 only when every out_hold bit is 1. It rises one edge after the last lane parks.
- R9: Suppose the pin is driven low just after edge M during parking or parked. restart_pulse is 1 for exactly one cycle from edge M+3, and all out_hold bits are set from edge M+4 at the latest. They stay set until pll_lock is high, and all clear at the edge where pll_lock is sampled high.
- R10: With test_sel=1, test_mode=0 gives tri_state=1 and ref_div_en=0, and test_mode=1 gives tri_state=0 and ref_div_en=1. With test_sel=0 both outputs are 0.
- R11: With test_sel=1 the capture re-arms. Each edge on which the synchronized pin is low latches the current straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_pd_pin | input | 1 | Shared pin: active-low power-good, then active-high power-down (asynchronous) |
| sel_hi | input | 1 | Upper frequency-select strap |
| sel_lo | input | 1 | Lower frequency-select strap |
| test_sel | input | 1 | 1 enters test mode |
| test_mode | input | 1 | In test mode: 0 tri-state, 1 divided reference |
| pll_lock | input | 1 | External lock indication |
| lane_level | input | NUM_OUT | Present level of each output lane's clock |
| straps_valid | output | 1 | Straps have been captured |
| strap_status | output | 2 | Latched straps {sel_hi, sel_lo} |
| rate_code | output | 2 | Decoded CPU rate code |
| out_hold | output | NUM_OUT | Per-lane park control, 1 = held at parked level |
| osc_off_ok | output | 1 | Oscillators may be shut off |
| restart_pulse | output | 1 | One-cycle pulse on power-down release |
| tri_state | output | 1 | Test mode: outputs tri-stated |
| ref_div_en | output | 1 | Test mode: outputs drive divided reference |

## Verification
Some rules are checked by the assertions on every cycle. The valid flag is sticky. The latched straps stay stable outside test mode. Shutdown permission implies that every lane is parked. The restart pulse lasts one cycle. No hold bit is released unless the lock input was high. No lane is held before the straps are captured. The two test outputs are never both active. Other properties depend on a sequence of events, so only the bench scenarios can show them. These are the exact capture and park latencies, the rejection of a one-cycle pin glitch, parking at each lane's own falling edge, a release during parking, and recapture in test mode.

// File: rtl/strap_pd_pkg.sv
package strap_pd_pkg;

    typedef enum logic [1:0] {
        RATE_100 = 2'd0,
        RATE_133 = 2'd1,
        RATE_166 = 2'd2,
        RATE_200 = 2'd3
    } cpu_rate_e;

    typedef enum logic [1:0] {
        SEQ_RUN       = 2'd0,
        SEQ_PARKING   = 2'd1,
        SEQ_PARKED    = 2'd2,
        SEQ_WAIT_LOCK = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic sel_hi;
        logic sel_lo;
    } strap_t;

    function automatic cpu_rate_e decode_rate(input strap_t s);
        cpu_rate_e r;
        case ({s.sel_hi, s.sel_lo})
            2'b10:   r = RATE_100;
            2'b00:   r = RATE_133;
            2'b01:   r = RATE_166;
            default: r = RATE_200;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic pin_lvl
);
    logic [STAGES-1:0] chain_q;

    // Reset to 1: the pin is inactive (power not yet good) at reset.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= pin_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign pin_lvl = chain_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_lvl,
    input  logic   rearm,
    input  strap_t straps_in,
    output strap_t straps_q,
    output logic   captured
);
    logic take;

    // One-shot unless re-armed by test mode; capture on a valid low.
    assign take = !pin_lvl && (!captured || rearm);

    always_ff @(posedge clk) begin
        if (rst) begin
            straps_q <= '0;
            captured <= 1'b0;
        end else if (take) begin
            straps_q <= straps_in;
            captured <= 1'b1;
        end
    end
endmodule

// File: rtl/pd_qualifier.sv
module pd_qualifier (
    input  logic clk,
    input  logic rst,
    input  logic pin_lvl,
    input  logic enable,
    output logic pd_req,
    output logic pd_release
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin_lvl;
    end

    // Two consecutive high samples qualify a request.
    assign pd_req     = enable && pin_lvl && prev_q;
    assign pd_release = !pin_lvl;
endmodule

// File: rtl/park_lane.sv
module park_lane (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic arm,
    input  logic force_hold,
    input  logic clear,
    output logic hold
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            hold  <= 1'b0;
        end else begin
            lvl_q <= lvl;
            if (clear)
                hold <= 1'b0;
            else if (force_hold)
                hold <= 1'b1;
            else if (arm && lvl_q && !lvl)
                hold <= 1'b1;
        end
    end
endmodule

// File: rtl/strap_pd_seq.sv
module strap_pd_seq
    import strap_pd_pkg::*;
#(
    parameter int NUM_OUT     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pg_pd_pin,
    input  logic               sel_hi,
    input  logic               sel_lo,
    input  logic               test_sel,
    input  logic               test_mode,
    input  logic               pll_lock,
    input  logic [NUM_OUT-1:0] lane_level,
    output logic               straps_valid,
    output logic [1:0]         strap_status,
    output logic [1:0]         rate_code,
    output logic [NUM_OUT-1:0] out_hold,
    output logic               osc_off_ok,
    output logic               restart_pulse,
    output logic               tri_state,
    output logic               ref_div_en
);
    logic       pin_lvl;
    strap_t     straps_in;
    strap_t     straps_q;
    logic       captured;
    logic       pd_req;
    logic       pd_release;
    seq_state_e state_q, state_d;
    logic       restart_q;
    logic       lane_arm, lane_force, lane_clear;
    logic       all_held;

    pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pg_pd_pin),
        .pin_lvl   (pin_lvl)
    );

    assign straps_in.sel_hi = sel_hi;
    assign straps_in.sel_lo = sel_lo;

    strap_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .pin_lvl   (pin_lvl),
        .rearm     (test_sel),
        .straps_in (straps_in),
        .straps_q  (straps_q),
        .captured  (captured)
    );

    pd_qualifier u_qual (
        .clk        (clk),
        .rst        (rst),
        .pin_lvl    (pin_lvl),
        .enable     (captured && !test_sel),
        .pd_req     (pd_req),
        .pd_release (pd_release)
    );

    assign lane_arm   = (state_q == SEQ_PARKING);
    assign lane_force = (state_q == SEQ_WAIT_LOCK) && !pll_lock;
    assign lane_clear = (state_q == SEQ_WAIT_LOCK) && pll_lock;

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
            park_lane u_lane (
                .clk        (clk),
                .rst        (rst),
                .lvl        (lane_level[i]),
                .arm        (lane_arm),
                .force_hold (lane_force),
                .clear      (lane_clear),
                .hold       (out_hold[i])
            );
        end
    endgenerate

    assign all_held = &out_hold;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_RUN:       if (pd_req) state_d = SEQ_PARKING;
            SEQ_PARKING: begin
                if (pd_release)    state_d = SEQ_WAIT_LOCK;
                else if (all_held) state_d = SEQ_PARKED;
            end
            SEQ_PARKED:    if (pd_release) state_d = SEQ_WAIT_LOCK;
            SEQ_WAIT_LOCK: if (pll_lock) state_d = SEQ_RUN;
            default:       state_d = SEQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_RUN;
            restart_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            restart_q <= (state_d == SEQ_WAIT_LOCK) && (state_q != SEQ_WAIT_LOCK);
        end
    end

    assign straps_valid  = captured;
    assign strap_status  = {straps_q.sel_hi, straps_q.sel_lo};
    assign rate_code     = decode_rate(straps_q);
    assign osc_off_ok    = (state_q == SEQ_PARKED);
    assign restart_pulse = restart_q;
    assign tri_state     = test_sel && !test_mode;
    assign ref_div_en    = test_sel && test_mode;
endmodule

// File: rtl/strap_pd_checker.sv
module strap_pd_checker #(
    parameter int NUM_OUT = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               test_sel,
    input logic               pll_lock,
    input logic               straps_valid,
    input logic [1:0]         strap_status,
    input logic [NUM_OUT-1:0] out_hold,
    input logic               osc_off_ok,
    input logic               restart_pulse,
    input logic               tri_state,
    input logic               ref_div_en
);
    a_r5_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        straps_valid |=> straps_valid);

    a_r4_status_frozen: assert property (@(posedge clk) disable iff (rst)
        (straps_valid && !test_sel) |=> $stable(strap_status));

    a_r8_off_needs_all_parked: assert property (@(posedge clk) disable iff (rst)
        osc_off_ok |-> (&out_hold));

    a_r9_restart_single: assert property (@(posedge clk) disable iff (rst)
        restart_pulse |=> !restart_pulse);

    a_r9_release_needs_lock: assert property (@(posedge clk) disable iff (rst)
        (|($past(out_hold) & ~out_hold)) |-> $past(pll_lock));

    a_r6_no_park_before_capture: assert property (@(posedge clk) disable iff (rst)
        !straps_valid |-> (out_hold == '0 && !osc_off_ok));

    a_r10_test_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(tri_state && ref_div_en));
endmodule

bind strap_pd_seq strap_pd_checker #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .test_sel      (test_sel),
    .pll_lock      (pll_lock),
    .straps_valid  (straps_valid),
    .strap_status  (strap_status),
    .out_hold      (out_hold),
    .osc_off_ok    (osc_off_ok),
    .restart_pulse (restart_pulse),
    .tri_state     (tri_state),
    .ref_div_en    (ref_div_en)
);

// File: tb/strap_pd_seq_bench.sv
`timescale 1ns/1ps
module strap_pd_seq_bench;
    localparam int N = 4;
    localparam logic [N-1:0] ALL = '1;

    logic clk = 1'b0;
    logic rst, pin, hi, lo, tsel, tmode, lock;
    logic [N-1:0] lanes;
    logic valid, osc_ok, restart, tri_s, refd;
    logic [1:0] status, rate;
    logic [N-1:0] hold;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    strap_pd_seq #(.NUM_OUT(N)) u_strap_pd_seq (
        .clk(clk), .rst(rst), .pg_pd_pin(pin), .sel_hi(hi), .sel_lo(lo),
        .test_sel(tsel), .test_mode(tmode), .pll_lock(lock), .lane_level(lanes),
        .straps_valid(valid), .strap_status(status), .rate_code(rate),
        .out_hold(hold), .osc_off_ok(osc_ok), .restart_pulse(restart),
        .tri_state(tri_s), .ref_div_en(refd)
    );

    function automatic logic [1:0] exp_rate(input logic h, input logic l);
        case ({h, l})
            2'b10: return 2'd0;
            2'b00: return 2'd1;
            2'b01: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic h2, l2;
        void'($urandom(32'd1234));
        rst = 1; pin = 1; hi = 0; lo = 0; tsel = 0; tmode = 0; lock = 0; lanes = ALL;
        tick(3);
        rst = 0;
        // R1 reset state
        check(valid == 0 && status == 2'b00 && rate == 2'd1, "R1", {valid, status, rate}, 5'b0_00_01);
        check(hold == '0 && !osc_ok && !restart, "R1", {hold, osc_ok, restart}, 0);

        for (int it = 0; it < 8; it++) begin
            rst = 1; pin = 1; tick(1); rst = 0;
            if (it < 4) begin hi = it[1]; lo = it[0]; end
            else begin hi = $urandom % 2; lo = $urandom % 2; end
            tick(1);
            pin = 0;
            tick(2);
            check(valid == 0, "R3 early", valid, 0);
            tick(1);
            check(valid == 1, "R3 valid", valid, 1);
            check(status == {hi, lo}, "R3 status", status, {hi, lo});
            check(rate == exp_rate(hi, lo), "R2 decode", rate, exp_rate(hi, lo));
            h2 = hi; l2 = lo;
            hi = ~hi; lo = $urandom % 2;
            tick(3);
            check(status == {h2, l2}, "R4 straps ignored", status, {h2, l2});
            if (it < 7) begin
                rst = 1; tick(1);
                check(valid == 0, "R5 reset clears", valid, 0);
                rst = 0;
            end else begin
                hi = h2; lo = l2;
            end
        end

        // R6 single-cycle glitch, lanes toggling
        h2 = status[1]; l2 = status[0];
        hi = ~h2;
        pin = 1; tick(1); pin = 0;
        for (int k = 0; k < 8; k++) begin
            lanes = (k % 2) ? ALL : '0;
            tick(1);
            check(hold == '0 && !osc_ok, "R6 glitch", hold, 0);
        end
        lanes = ALL;
        check(status == {h2, l2}, "R4 pin ignored", status, {h2, l2});
        hi = h2;

        // R6 test mode suppresses power-down; R10 outputs
        tsel = 1; tmode = 0; #1;
        check(tri_s == 1 && refd == 0, "R10 tristate", {tri_s, refd}, 2'b10);
        tmode = 1; #1;
        check(tri_s == 0 && refd == 1, "R10 refdiv", {tri_s, refd}, 2'b01);
        pin = 1;
        for (int k = 0; k < 8; k++) begin
            lanes = (k % 2) ? ALL : '0;
            tick(1);
            check(hold == '0, "R6 test blocks pd", hold, 0);
        end
        lanes = ALL;
        pin = 0; tick(3);
        // R11 recapture in test mode
        hi = ~h2; lo = ~l2;
        tick(1);
        check(status == {~h2, ~l2}, "R11 recapture", status, {~h2, ~l2});
        check(rate == exp_rate(~h2, ~l2), "R2 after recapture", rate, exp_rate(~h2, ~l2));
        tsel = 0; tmode = 0; tick(1);
        check(tri_s == 0 && refd == 0, "R10 normal", {tri_s, refd}, 0);

        // R7/R8 power-down
        pin = 1;
        tick(3);
        check(hold == '0 && !osc_ok, "R6 not yet", hold, 0);
        tick(1);
        lanes = ALL & ~1;
        tick(1);
        check(hold == 1, "R7 lane0 parks", hold, 1);
        check(!osc_ok, "R8 partial", osc_ok, 0);
        lanes = '0;
        tick(1);
        check(hold == ALL, "R7 all park", hold, ALL);
        check(!osc_ok, "R8 one edge later", osc_ok, 0);
        tick(1);
        check(osc_ok == 1, "R8 off ok", osc_ok, 1);
        for (int k = 0; k < 4; k++) begin
            lanes = (k % 2) ? ALL : '0;
            tick(1);
            check(hold == ALL, "R7 stays parked", hold, ALL);
        end

        // R9 release from parked
        pin = 0;
        tick(2);
        check(!restart && osc_ok, "R9 before", {restart, osc_ok}, 2'b01);
        tick(1);
        check(restart && !osc_ok && hold == ALL, "R9 pulse", {restart, osc_ok, hold}, {2'b10, ALL});
        tick(1);
        check(!restart, "R9 single", restart, 0);
        tick(5);
        check(hold == ALL, "R9 wait lock", hold, ALL);
        lock = 1; tick(1); lock = 0;
        check(hold == '0, "R9 lock clears", hold, 0);

        // R9 release during parking
        lanes = ALL;
        pin = 1; tick(4);
        lanes = ALL & ~4'b0100;
        tick(1);
        check(hold == 4'b0100, "R7 lane2 parks", hold, 4'b0100);
        pin = 0; tick(3);
        check(restart && hold == 4'b0100 && !osc_ok, "R9 pulse from parking", {restart, hold}, {1'b1, 4'b0100});
        tick(1);
        check(hold == ALL && !restart && !osc_ok, "R9 forced hold", {restart, hold}, {1'b0, ALL});
        lock = 1; tick(1); lock = 0;
        check(hold == '0, "R9 lock clears 2", hold, 0);
        check(valid == 1, "R5 still valid", valid, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule